// File: doc/BRIEF.md
# Coprocessor Operation Decoder with Access Check

This block examines one 32-bit instruction word of a MIPS-style core. It finds out whether the word belongs to the coprocessor families: a coprocessor command, a word load into a coprocessor, or a word store from a coprocessor. It then names the coprocessor, sorts the operation into a class, and decides whether the operation may go ahead or must raise a coprocessor-unusable exception. The core's execute stage uses the class to steer the operation and the exception request to start a trap. The block does not execute any operation and does not compute memory addresses.

The decoder is purely combinational. It has no states and no transitions. Its outputs follow the instruction word, the user-mode flag and the per-coprocessor usable bits within the same cycle. A word outside the three families drives every output to zero. Coprocessors 1 and 3 are absent, so any operation that names them always traps. Coprocessors 0 and 2 trap only in user mode while their usable bit is clear. When a trap and an unimplemented encoding occur together, the trap wins and the unimplemented flag stays low.

Top module: `cop_decode_unit`

## Requirements
- R1: A word is recognised, with `is_cop_o`=1 and `cop_num_o` equal to opcode bits 1:0, when its opcode (bits 31:26) is 16 to 19 (command), 48 to 51 (load to coprocessor) or 56 to 59 (store from coprocessor).
- R2: For any other opcode, every output is zero: `is_cop_o`, `cop_num_o`, `op_class_o`, `unusable_o`, `unusable_num_o` and `unimpl_o`.
- R3: For a command word with bit 25 clear, bits 24:21 select the class. 0000 gives move-from (class 1), 0010 gives control-from (2), 0100 gives move-to (3) and 0110 gives control-to (4), all with `unimpl_o`=0 when there is no trap.
- R4: A common code of 1000 gives branch-on-condition (class 5) with `unimpl_o`=1. Any common code not named in R3 or R4 gives class 9 with `unimpl_o`=1. Both cases apply only when there is no trap.
- R5: A command word with bit 25 set works as follows. On coprocessor 0, bits 5:0 equal to 0x10 give return-from-exception (class 6). Any other value, including the translation-buffer codes 0x01, 0x02, 0x04 and 0x08, gives class 9 with `unimpl_o`=1. On coprocessors 1, 2 and 3, bit 25 set always gives class 9.
- R6: Load opcodes give class 7 and store opcodes give class 8, with `unimpl_o`=0.
- R7: A coprocessor 0 operation sets `unusable_o`=1 with `unusable_num_o`=0 exactly when `user_mode_i`=1 and `cop_usable_i[0]`=0. In kernel mode it never traps.
- R8: A coprocessor 2 operation (command, load or store) sets `unusable_o`=1 with `unusable_num_o`=2 exactly when `user_mode_i`=1 and `cop_usable_i[2]`=0.
- R9: Any operation on coprocessor 1 or 3 sets `unusable_o`=1 with `unusable_num_o` equal to 1 or 3, whatever the mode and the usable bits.
- R10: While `unusable_o`=1, `unimpl_o` is 0. While `unusable_o`=0, `unusable_num_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word under decode |
| user_mode_i | input | 1 | 1 when the core runs in user mode |
| cop_usable_i | input | 4 | Usable bit per coprocessor, bit n for coprocessor n |
| is_cop_o | output | 1 | Word belongs to a coprocessor family |
| cop_num_o | output | 2 | Coprocessor addressed by the word |
| op_class_o | output | 4 | Operation class: 0 none, 1 move-from, 2 control-from, 3 move-to, 4 control-to, 5 branch-on-condition, 6 return-from-exception, 7 load, 8 store, 9 unimplemented |
| unusable_o | output | 1 | Coprocessor-unusable exception request |
| unusable_num_o | output | 2 | Coprocessor number carried with the exception |
| unimpl_o | output | 1 | Encoding is recognised but not implemented |

## Verification
The exception request and the unimplemented flag can fall on the same word. A branch-on-condition, a translation-buffer op or an unlisted common code on coprocessor 1 or 3 triggers both, and so does the same word on coprocessor 0 or 2 in user mode with the usable bit clear. Directed words provoke these cases, and a long stream of pseudo-random words does as well: half of them have their opcode forced into a coprocessor family, and the mode and usable bits vary. On every clock, the bench compares all six outputs against a behavioural model. That model decides the trap first and lets it mask the unimplemented flag.

// File: rtl/cop_dec_pkg.sv
package cop_dec_pkg;

    localparam int INSN_W  = 32;
    localparam int OPC_W   = 6;
    localparam int NCOP    = 4;
    localparam int COPN_W  = $clog2(NCOP);
    localparam int CODE_W  = 4;
    localparam int FUNCT_W = 6;
    localparam int CLASS_W = 4;

    typedef enum logic [CLASS_W-1:0] {
        OPC_NONE        = 4'd0,
        OPC_MOVE_FROM   = 4'd1,
        OPC_CTRL_FROM   = 4'd2,
        OPC_MOVE_TO     = 4'd3,
        OPC_CTRL_TO     = 4'd4,
        OPC_BRANCH_COND = 4'd5,
        OPC_RET_EXC     = 4'd6,
        OPC_LOAD_TO     = 4'd7,
        OPC_STORE_FROM  = 4'd8,
        OPC_UNIMPL      = 4'd9
    } cop_class_e;

    typedef enum logic [1:0] {
        FAM_NONE  = 2'd0,
        FAM_CMD   = 2'd1,
        FAM_LOAD  = 2'd2,
        FAM_STORE = 2'd3
    } cop_family_e;

    typedef struct packed {
        cop_family_e         fam;
        logic [COPN_W-1:0]   num;
        logic                cmd_sel;
        logic [CODE_W-1:0]   common_code;
        logic [FUNCT_W-1:0]  funct;
    } cop_fields_t;

    localparam logic [3:0]         GRP_CMD    = 4'b0100;
    localparam logic [3:0]         GRP_LOAD   = 4'b1100;
    localparam logic [3:0]         GRP_STORE  = 4'b1110;
    localparam logic [FUNCT_W-1:0] FUNCT_RFE  = 6'h10;

endpackage

// File: rtl/cop_field_split.sv
module cop_field_split
    import cop_dec_pkg::*;
(
    input  logic [INSN_W-1:0] instr_i,
    output cop_fields_t       fields_o
);
    logic [OPC_W-1:0] opc;
    logic             unused_mid;

    assign opc        = instr_i[INSN_W-1 -: OPC_W];
    assign unused_mid = ^instr_i[20:6];

    always_comb begin
        fields_o             = '0;
        fields_o.num         = opc[COPN_W-1:0];
        fields_o.cmd_sel     = instr_i[25];
        fields_o.common_code = instr_i[24:21];
        fields_o.funct       = instr_i[FUNCT_W-1:0];
        unique case (opc[OPC_W-1:COPN_W])
            GRP_CMD:   fields_o.fam = FAM_CMD;
            GRP_LOAD:  fields_o.fam = FAM_LOAD;
            GRP_STORE: fields_o.fam = FAM_STORE;
            default:   fields_o.fam = FAM_NONE;
        endcase
    end
endmodule

// File: rtl/cop_class_decode.sv
module cop_class_decode
    import cop_dec_pkg::*;
(
    input  cop_fields_t fields_i,
    output cop_class_e  class_o,
    output logic        unimpl_o
);
    cop_class_e common_cls;
    logic       common_unimpl;
    cop_class_e own_cls;
    logic       own_unimpl;

    always_comb begin
        common_unimpl = 1'b0;
        unique case (fields_i.common_code)
            4'b0000: common_cls = OPC_MOVE_FROM;
            4'b0010: common_cls = OPC_CTRL_FROM;
            4'b0100: common_cls = OPC_MOVE_TO;
            4'b0110: common_cls = OPC_CTRL_TO;
            4'b1000: begin
                common_cls    = OPC_BRANCH_COND;
                common_unimpl = 1'b1;
            end
            default: begin
                common_cls    = OPC_UNIMPL;
                common_unimpl = 1'b1;
            end
        endcase
    end

    always_comb begin
        if (fields_i.num == '0 && fields_i.funct == FUNCT_RFE) begin
            own_cls    = OPC_RET_EXC;
            own_unimpl = 1'b0;
        end else begin
            own_cls    = OPC_UNIMPL;
            own_unimpl = 1'b1;
        end
    end

    always_comb begin
        unique case (fields_i.fam)
            FAM_CMD: begin
                class_o  = fields_i.cmd_sel ? own_cls : common_cls;
                unimpl_o = fields_i.cmd_sel ? own_unimpl : common_unimpl;
            end
            FAM_LOAD: begin
                class_o  = OPC_LOAD_TO;
                unimpl_o = 1'b0;
            end
            FAM_STORE: begin
                class_o  = OPC_STORE_FROM;
                unimpl_o = 1'b0;
            end
            default: begin
                class_o  = OPC_NONE;
                unimpl_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/cop_access_gate.sv
module cop_access_gate #(
    parameter int               N_COP       = 4,
    parameter logic [N_COP-1:0] ABSENT_MASK = 4'b1010,
    localparam int              SEL_W       = $clog2(N_COP)
) (
    input  logic             valid_i,
    input  logic [SEL_W-1:0] num_i,
    input  logic             user_mode_i,
    input  logic [N_COP-1:0] usable_i,
    output logic             trap_o
);
    logic [N_COP-1:0] lane_trap;

    for (genvar g = 0; g < N_COP; g++) begin : g_lane
        if (ABSENT_MASK[g]) begin : g_absent
            assign lane_trap[g] = 1'b1;
            logic unused_bit;
            assign unused_bit = usable_i[g];
        end else begin : g_present
            assign lane_trap[g] = user_mode_i & ~usable_i[g];
        end
    end

    assign trap_o = valid_i & lane_trap[num_i];
endmodule

// File: rtl/cop_decode_unit.sv
module cop_decode_unit
    import cop_dec_pkg::*;
(
    input  logic [31:0] instr_i,
    input  logic        user_mode_i,
    input  logic [3:0]  cop_usable_i,
    output logic        is_cop_o,
    output logic [1:0]  cop_num_o,
    output logic [3:0]  op_class_o,
    output logic        unusable_o,
    output logic [1:0]  unusable_num_o,
    output logic        unimpl_o
);
    cop_fields_t fields;
    cop_class_e  cls;
    logic        cls_unimpl;
    logic        hit;
    logic        trap;

    cop_field_split u_split (
        .instr_i  (instr_i),
        .fields_o (fields)
    );

    cop_class_decode u_class (
        .fields_i (fields),
        .class_o  (cls),
        .unimpl_o (cls_unimpl)
    );

    assign hit = (fields.fam != FAM_NONE);

    cop_access_gate #(
        .N_COP       (NCOP),
        .ABSENT_MASK (4'b1010)
    ) u_gate (
        .valid_i     (hit),
        .num_i       (fields.num),
        .user_mode_i (user_mode_i),
        .usable_i    (cop_usable_i),
        .trap_o      (trap)
    );

    assign is_cop_o       = hit;
    assign cop_num_o      = hit ? fields.num : '0;
    assign op_class_o     = cls;
    assign unusable_o     = trap;
    assign unusable_num_o = trap ? fields.num : '0;
    assign unimpl_o       = cls_unimpl & ~trap;
endmodule

// File: rtl/cop_decode_unit_chk.sv
module cop_decode_unit_chk (
    input logic [31:0] instr_i,
    input logic        user_mode_i,
    input logic [3:0]  cop_usable_i,
    input logic        is_cop_o,
    input logic [1:0]  cop_num_o,
    input logic [3:0]  op_class_o,
    input logic        unusable_o,
    input logic [1:0]  unusable_num_o,
    input logic        unimpl_o
);
    always_comb begin
        AST_IDLE_ZERO: assert (is_cop_o || (op_class_o == 4'd0 && !unusable_o && !unimpl_o && cop_num_o == 2'd0)); // R2
        AST_ABSENT_TRAPS: assert (!(is_cop_o && cop_num_o[0]) || unusable_o); // R9
        AST_KERNEL_COP0: assert (!(is_cop_o && !user_mode_i && cop_num_o == 2'd0) || !unusable_o); // R7
        AST_COP2_GRANTED: assert (!(is_cop_o && cop_num_o == 2'd2 && (!user_mode_i || cop_usable_i[2])) || !unusable_o); // R8
        AST_TRAP_MASKS_UNIMPL: assert (!(unusable_o && unimpl_o)); // R10
        AST_TRAP_NUM_MATCH: assert (unusable_o ? (unusable_num_o == cop_num_o) : (unusable_num_o == 2'd0)); // R10
        AST_CLASS_RANGE: assert (op_class_o <= 4'd9); // R3
        AST_LDST_IMPL: assert (!(op_class_o == 4'd7 || op_class_o == 4'd8) || !unimpl_o); // R6
        AST_FAMILY_OPC: assert (!is_cop_o || instr_i[31:28] == 4'b0100 || instr_i[31:28] == 4'b1100 || instr_i[31:28] == 4'b1110); // R1
    end
endmodule

bind cop_decode_unit cop_decode_unit_chk u_chk (
    .instr_i        (instr_i),
    .user_mode_i    (user_mode_i),
    .cop_usable_i   (cop_usable_i),
    .is_cop_o       (is_cop_o),
    .cop_num_o      (cop_num_o),
    .op_class_o     (op_class_o),
    .unusable_o     (unusable_o),
    .unusable_num_o (unusable_num_o),
    .unimpl_o       (unimpl_o)
);

// File: tb/cop_decode_unit_tb_top.sv
module cop_decode_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr;
    logic        umode;
    logic [3:0]  cu;
    logic        is_cop;
    logic [1:0]  cnum;
    logic [3:0]  ocls;
    logic        unus;
    logic [1:0]  unum;
    logic        unimp;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    cop_decode_unit dut_i (
        .instr_i        (instr),
        .user_mode_i    (umode),
        .cop_usable_i   (cu),
        .is_cop_o       (is_cop),
        .cop_num_o      (cnum),
        .op_class_o     (ocls),
        .unusable_o     (unus),
        .unusable_num_o (unum),
        .unimpl_o       (unimp)
    );

    // behavioural reference, packed as {is,num,class,trap,tnum,unimpl}
    function automatic logic [10:0] ref_model(input logic [31:0] w, input logic um, input logic [3:0] u);
        int op, n, cls, code, fn;
        bit fam, tr, ui;
        op = int'(w[31:26]);
        n = op % 4;
        code = int'(w[24:21]);
        fn = int'(w[5:0]);
        fam = 1'b1; ui = 1'b0; cls = 0;
        if (op >= 16 && op <= 19) begin
            if (w[25] == 1'b0) begin
                if (code == 0) cls = 1;
                else if (code == 2) cls = 2;
                else if (code == 4) cls = 3;
                else if (code == 6) cls = 4;
                else if (code == 8) begin cls = 5; ui = 1'b1; end
                else begin cls = 9; ui = 1'b1; end
            end else if (n == 0 && fn == 16) cls = 6;
            else begin cls = 9; ui = 1'b1; end
        end else if (op >= 48 && op <= 51) cls = 7;
        else if (op >= 56 && op <= 59) cls = 8;
        else fam = 1'b0;
        if (!fam) return 11'd0;
        tr = (n == 1 || n == 3) || (um && !u[n]);
        if (tr) ui = 1'b0;
        return {1'b1, 2'(n), 4'(cls), tr, tr ? 2'(n) : 2'd0, ui};
    endfunction

    task automatic apply(input logic [31:0] w, input logic um, input logic [3:0] u, input string tag);
        logic [10:0] exp_v, act_v;
        @(negedge clk);
        instr = w; umode = um; cu = u;
        @(posedge clk);
        #1;
        exp_v = ref_model(w, um, u);
        act_v = {is_cop, cnum, ocls, unus, unum, unimp};
        checks++;
        if (act_v !== exp_v) begin
            fails++;
            $display("FAIL %s instr=%08h user=%0b cu=%04b actual=%03h expected=%03h", tag, w, um, u, act_v, exp_v);
        end
    endtask

    function automatic logic [31:0] cmn(input int op, input logic [3:0] c);
        return {6'(op), 1'b0, c, 21'h0A5A5};
    endfunction

    function automatic logic [31:0] own(input int op, input logic [5:0] f);
        return {6'(op), 1'b1, 19'h12345, f};
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] lfsr;
        instr = 32'h0; umode = 1'b0; cu = 4'h0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R2: reset/idle state and non-coprocessor words
        apply(32'h0000_0000, 1'b1, 4'h0, "R2 idle");
        apply(32'h8C22_0004, 1'b1, 4'h0, "R2 lw");
        apply(32'h5400_0000, 1'b1, 4'h0, "R2 op21");
        apply(32'hFC00_0010, 1'b0, 4'hF, "R2 op63");
        // R1 recognition of all coprocessor numbers
        for (int op = 16; op <= 19; op++) apply(cmn(op, 4'b0000), 1'b0, 4'hF, "R1 cmd");
        // R3 common codes on cop0 and cop2, kernel
        apply(cmn(16, 4'b0000), 1'b0, 4'h0, "R3 mf");
        apply(cmn(16, 4'b0010), 1'b0, 4'h0, "R3 cf");
        apply(cmn(18, 4'b0100), 1'b0, 4'h0, "R3 mt");
        apply(cmn(18, 4'b0110), 1'b1, 4'h4, "R3 ct");
        // R4 branch and unlisted codes
        apply(cmn(16, 4'b1000), 1'b0, 4'h0, "R4 bc");
        apply(cmn(18, 4'b0001), 1'b0, 4'h0, "R4 code1");
        apply(cmn(16, 4'b1111), 1'b1, 4'h1, "R4 code15");
        // R5 coprocessor-specific commands
        apply(own(16, 6'h10), 1'b0, 4'h0, "R5 rfe");
        apply(own(16, 6'h01), 1'b0, 4'h0, "R5 tlb1");
        apply(own(16, 6'h02), 1'b0, 4'h0, "R5 tlb2");
        apply(own(16, 6'h04), 1'b0, 4'h0, "R5 tlb4");
        apply(own(16, 6'h08), 1'b0, 4'h0, "R5 tlb8");
        apply(own(18, 6'h10), 1'b0, 4'h0, "R5 cop2cmd");
        // R6 loads and stores
        apply({6'd50, 26'h1234567}, 1'b0, 4'h0, "R6 lwc2");
        apply({6'd58, 26'h0ABCDEF}, 1'b1, 4'h4, "R6 swc2");
        apply({6'd48, 26'h0000001}, 1'b0, 4'h0, "R6 lwc0");
        apply({6'd56, 26'h3FFFFFF}, 1'b1, 4'h1, "R6 swc0");
        // R7 coprocessor 0 access
        apply(cmn(16, 4'b0100), 1'b1, 4'hE, "R7 user cu0 clear");
        apply(cmn(16, 4'b0100), 1'b0, 4'h0, "R7 kernel");
        apply(cmn(16, 4'b0100), 1'b1, 4'h1, "R7 user cu0 set");
        // R8 coprocessor 2 access
        apply(cmn(18, 4'b0000), 1'b1, 4'hB, "R8 user cu2 clear");
        apply({6'd50, 26'h0}, 1'b1, 4'h0, "R8 lwc2 trap");
        apply({6'd58, 26'h0}, 1'b1, 4'h0, "R8 swc2 trap");
        apply(cmn(18, 4'b0000), 1'b1, 4'h4, "R8 user cu2 set");
        apply(cmn(18, 4'b0000), 1'b0, 4'h0, "R8 kernel");
        // R9 absent coprocessors
        apply(cmn(17, 4'b0000), 1'b0, 4'hF, "R9 cop1");
        apply(cmn(19, 4'b0100), 1'b0, 4'hF, "R9 cop3");
        apply({6'd49, 26'h0}, 1'b0, 4'hF, "R9 lwc1");
        apply({6'd59, 26'h0}, 1'b0, 4'hF, "R9 swc3");
        // R10 trap masks unimplemented (collision cases)
        apply(own(16, 6'h08), 1'b1, 4'h0, "R10 tlb trap");
        apply(cmn(17, 4'b1000), 1'b0, 4'hF, "R10 bc1");
        apply(cmn(18, 4'b1000), 1'b1, 4'h0, "R10 bc2 trap");
        apply(own(19, 6'h10), 1'b0, 4'hF, "R10 cop3 cmd");
        // pseudo-random sweep
        lfsr = 32'hACE1_2468;
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] w;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            w = lfsr ^ {lfsr[15:0], lfsr[31:16]};
            if (lfsr[3]) w[31:28] = lfsr[5] ? 4'b0100 : (lfsr[6] ? 4'b1100 : 4'b1110);
            apply(w, lfsr[9], lfsr[13:10], "R1 random");
        end
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule